// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block turns a stream of phase samples into an instantaneous frequency estimate. Each phase sample arrives with a one-cycle valid strobe from an upstream rectangular-to-polar converter. The sample can first be scaled by 1, 2, 4 or 8, with the result wrapping modulo one full turn. This strips BPSK, QPSK or 8PSK symbol modulation so that only the carrier rotation is left. The scaled phase is then compared with the scaled phase from N valid samples earlier. The wrapped difference is rounded to a narrower word and presented with its own valid strobe.

Three static-style configuration inputs control the block: an enable, a two-bit multiplier code and a three-bit delay count. Phase is a two's-complement fraction of a full turn, so every wrap in the datapath is ordinary binary overflow. The reset input is asynchronous and active low. Internally, its release is synchronised to the clock over two flops, so the block leaves reset two rising edges after rst_n goes high.

Top module: `phase_freq_disc`

## Requirements
- R1: While in reset and after reset until the first accepted sample, out_valid is 0 and out_freq is 0.
- R2: The scaled phase is the input phase shifted left by cfg_mult bit positions, keeping the low 18 bits. This is the input times 2^cfg_mult modulo a full turn: code 00 is x1 (CW), 01 is x2 (BPSK), 10 is x4 (QPSK), 11 is x8 (8PSK).
- R3: For each accepted sample, the 18-bit difference is the scaled phase minus the scaled phase stored N accepted samples earlier, wrapping modulo 2^18.
- R4: out_freq is formed by adding 2 to the 18-bit difference, wrapping modulo 2^18, and then taking bits 17..2 of the sum.
- R5: N equals cfg_delay for values 1 to 7, and a cfg_delay of 0 is treated as N = 1.
- R6: The delay history moves forward only on cycles where in_valid is 1 while the block is enabled. Cycles where in_valid is 0 leave it unchanged.
- R7: out_valid is 1 exactly in the cycle after an accepted sample, and out_freq changes in that same cycle. At all other times out_freq holds its last value.
- R8: While cfg_enable is 0, out_valid stays 0, out_freq holds, and the history is cleared to zero. After the block is re-enabled, history entries not yet refilled count as phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Discriminator enable |
| cfg_mult | input | 2 | Phase multiplier code (2^code) |
| cfg_delay | input | 3 | Differencing delay in samples (0 means 1) |
| in_valid | input | 1 | Phase sample strobe |
| in_phase | input | 18 | Phase, two's-complement fraction of a turn |
| out_valid | output | 1 | Frequency result strobe |
| out_freq | output | 16 | Rounded frequency estimate |

## Verification
The embedded properties assume the configuration inputs and the strobe are synchronous to clk and settled before each rising edge. They make no assumption about how often strobes arrive or how often the configuration changes between strobes. The stimulus drives every input on the falling edge. It mixes random phases, random strobe gaps and occasional random changes of multiplier, delay and enable. Directed sequences are added that exercise the wrap points of the rounding step, every multiplier code, the zero-delay case and re-enabling after a disabled interval.

// File: rtl/phdisc_pkg.sv
package phdisc_pkg;

  // Multiplier codes: scale factor is 2**code.
  typedef enum logic [1:0] {
    MUL_X1 = 2'b00,
    MUL_X2 = 2'b01,
    MUL_X4 = 2'b10,
    MUL_X8 = 2'b11
  } mult_e;

  localparam int unsigned MULT_W = 2;

endpackage

// File: rtl/phdisc_rst_sync.sv
module phdisc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/phdisc_scaler.sv
module phdisc_scaler
  import phdisc_pkg::*;
#(
  parameter int unsigned PHASE_W = 18
) (
  input  logic [PHASE_W-1:0] phase_i,
  input  mult_e              mult_i,
  output logic [PHASE_W-1:0] scaled_o
);

  // Phase is a fraction of a turn: a left shift wraps modulo 2*pi.
  always_comb begin
    unique case (mult_i)
      MUL_X1:  scaled_o = phase_i;
      MUL_X2:  scaled_o = {phase_i[PHASE_W-2:0], 1'b0};
      MUL_X4:  scaled_o = {phase_i[PHASE_W-3:0], 2'b00};
      MUL_X8:  scaled_o = {phase_i[PHASE_W-4:0], 3'b000};
      default: scaled_o = phase_i;
    endcase
  end

endmodule

// File: rtl/phdisc_delay_line.sv
module phdisc_delay_line #(
  parameter int unsigned WIDTH = 18,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned DEPTH = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic [SEL_W-1:0] sel_i,   // 1..DEPTH
  output logic [WIDTH-1:0] tap_o
);

  logic [DEPTH-1:0][WIDTH-1:0] line_q;
  logic [DEPTH-1:0][WIDTH-1:0] line_d;
  logic                        stage_en;

  assign stage_en = clr_i | adv_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_head
      assign src = din_i;
    end else begin : g_body
      assign src = line_q[g-1];
    end

    always_comb begin
      line_d[g] = clr_i ? '0 : src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[g] <= '0;
      end else if (stage_en) begin
        line_q[g] <= line_d[g];
      end
    end
  end

  always_comb begin
    tap_o = line_q[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (sel_i == SEL_W'(i + 1)) tap_o = line_q[i];
    end
  end

  // R8: clearing empties the whole history
  a_r8_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (line_q == '0));

  // R6: no advance, no change
  a_r6_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !adv_i) |=> $stable(line_q));

  // R6: on advance the newest entry is the sample just taken
  a_r6_line_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && adv_i) |=> (line_q[0] == $past(din_i)));

endmodule

// File: rtl/phase_freq_disc.sv
module phase_freq_disc
  import phdisc_pkg::*;
#(
  parameter int unsigned PHASE_W = 18,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned DLY_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [1:0]         cfg_mult,
  input  logic [DLY_W-1:0]   cfg_delay,
  input  logic               in_valid,
  input  logic [PHASE_W-1:0] in_phase,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_freq
);

  localparam int unsigned DROP_W = PHASE_W - OUT_W;
  localparam logic [PHASE_W-1:0] HALF_LSB = PHASE_W'(1) << (DROP_W - 1);

  logic               rst_n_s;
  logic [PHASE_W-1:0] scaled;
  logic [PHASE_W-1:0] tap;
  logic [PHASE_W-1:0] diff;
  logic [PHASE_W-1:0] biased;
  logic [DLY_W-1:0]   eff_dly;
  logic               accept;
  logic               vld_d, vld_q;
  logic [OUT_W-1:0]   freq_d, freq_q;

  phdisc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  phdisc_scaler #(.PHASE_W(PHASE_W)) u_scale (
    .phase_i  (in_phase),
    .mult_i   (mult_e'(cfg_mult)),
    .scaled_o (scaled)
  );

  assign accept  = in_valid & cfg_enable;
  assign eff_dly = (cfg_delay == '0) ? DLY_W'(1) : cfg_delay;

  phdisc_delay_line #(.WIDTH(PHASE_W), .SEL_W(DLY_W)) u_line (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr_i (~cfg_enable),
    .adv_i (accept),
    .din_i (scaled),
    .sel_i (eff_dly),
    .tap_o (tap)
  );

  // Wrapping difference, then add half an output LSB and truncate.
  always_comb begin
    diff   = scaled - tap;
    biased = diff + HALF_LSB;
    freq_d = biased[PHASE_W-1 -: OUT_W];
    vld_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      freq_q <= '0;
    end else if (accept) begin
      freq_q <= freq_d;
    end
  end

  assign out_valid = vld_q;
  assign out_freq  = freq_q;

  // R8: disabled means no strobe
  a_r8_no_strobe_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cfg_enable |=> !out_valid);

  // R7: accepted sample yields a strobe next cycle
  a_r7_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_enable && in_valid) |=> out_valid);

  // R7: no accepted sample, output holds and strobe stays low
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(cfg_enable && in_valid) |=> (!out_valid && $stable(out_freq)));

  // R5: the selected delay is always inside 1..7
  a_r5_delay_range: assert property (@(posedge clk) disable iff (!rst_n_s)
    eff_dly != '0);

endmodule

// File: tb/phase_freq_disc_tb.sv
module phase_freq_disc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable;
  logic [1:0]  cfg_mult;
  logic [2:0]  cfg_delay;
  logic        in_valid;
  logic [17:0] in_phase;
  logic        out_valid;
  logic [15:0] out_freq;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          finished = 1'b0;

  logic [17:0] hist [0:6];
  logic [15:0] last_freq;

  always #5 clk = ~clk;

  phase_freq_disc dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_mult   (cfg_mult),
    .cfg_delay  (cfg_delay),
    .in_valid   (in_valid),
    .in_phase   (in_phase),
    .out_valid  (out_valid),
    .out_freq   (out_freq)
  );

  function automatic logic [17:0] scale_ref(logic [17:0] p, logic [1:0] c);
    logic [17:0] r = p;
    for (int k = 0; k < int'(c); k++) r = r * 18'd2;
    return r;
  endfunction

  function automatic logic [15:0] round_ref(logic [17:0] d);
    logic [17:0] s = d + 18'd2;
    return s[17:2];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int k = 0; k < 7; k++) hist[k] = '0;
  endtask

  // One clock: drive on the falling edge, check just after the rising edge.
  task automatic step(logic en, logic v, logic [17:0] ph, logic [1:0] code,
                      logic [2:0] dly, string req);
    logic [17:0] sc, tp;
    logic [15:0] exp_f;
    int          n;
    cfg_enable = en; in_valid = v; in_phase = ph;
    cfg_mult = code; cfg_delay = dly;
    if (!en) begin
      clear_hist();
      @(posedge clk); #2;
      check({"R8 ", req}, {31'd0, out_valid}, 32'd0);
      check({"R8 ", req}, {16'd0, out_freq}, {16'd0, last_freq});
    end else if (v) begin
      sc = scale_ref(ph, code);
      n = (dly == 3'd0) ? 1 : int'(dly);
      tp = hist[n-1];
      exp_f = round_ref(sc - tp);
      for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = sc;
      @(posedge clk); #2;
      check({"R7 ", req}, {31'd0, out_valid}, 32'd1);
      check({"R3 ", req}, {16'd0, out_freq}, {16'd0, exp_f});
      last_freq = exp_f;
    end else begin
      @(posedge clk); #2;
      check({"R7 ", req}, {31'd0, out_valid}, 32'd0);
      check({"R6 ", req}, {16'd0, out_freq}, {16'd0, last_freq});
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [1:0]  rc;
    logic [2:0]  rd;
    logic        re;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_mult = 2'b00; cfg_delay = 3'd1;
    in_valid = 1'b0; in_phase = '0;
    last_freq = '0;
    clear_hist();
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset freq", {16'd0, out_freq}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {31'd0, out_valid}, 32'd0);
    check("R1 idle freq", {16'd0, out_freq}, 32'd0);

    // R2: each multiplier code, delay 1
    step(1, 1, 18'h3FFFF, 2'b11, 3'd1, "R2 x8 of -1");
    step(1, 1, 18'h12345, 2'b01, 3'd1, "R2 x2");
    step(1, 1, 18'h2ABCD, 2'b10, 3'd1, "R2 x4");
    step(1, 1, 18'h1F0F0, 2'b00, 3'd1, "R2 x1");
    // R4: rounding boundaries (diff of 1, 2, 3 and near positive wrap)
    step(1, 1, 18'h00000, 2'b00, 3'd1, "R4 base");
    step(1, 1, 18'h00001, 2'b00, 3'd1, "R4 diff1");
    step(1, 1, 18'h00003, 2'b00, 3'd1, "R4 diff2");
    step(1, 1, 18'h00006, 2'b00, 3'd1, "R4 diff3");
    step(1, 1, 18'h20004, 2'b00, 3'd1, "R4 wrap 1FFFE");
    // R5: zero delay behaves as one, then longer delays
    step(1, 1, 18'h00100, 2'b00, 3'd0, "R5 delay0");
    step(1, 1, 18'h00200, 2'b00, 3'd7, "R5 delay7");
    step(1, 1, 18'h00300, 2'b00, 3'd4, "R5 delay4");
    // R6: idle cycles do not move history
    step(1, 0, 18'h3AAAA, 2'b00, 3'd2, "R6 idle");
    step(1, 0, 18'h15555, 2'b00, 3'd2, "R6 idle");
    step(1, 1, 18'h00400, 2'b00, 3'd2, "R6 after idle");
    // R8: disable clears history, then first sample counts against zero
    step(0, 1, 18'h11111, 2'b01, 3'd3, "R8 off");
    step(0, 1, 18'h22222, 2'b01, 3'd3, "R8 off");
    step(1, 1, 18'h0ABCD, 2'b01, 3'd3, "R8 reenable");
    step(1, 1, 18'h0BCDE, 2'b01, 3'd3, "R8 second");

    rc = 2'b00; rd = 3'd1; re = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) rc = 2'($urandom);
      if (($urandom % 16) == 0) rd = 3'($urandom);
      if (($urandom % 40) == 0) re = ~re;
      else if (!re && ($urandom % 4) == 0) re = 1'b1;
      step(re, ($urandom % 10) < 7, 18'($urandom), rc, rd, "R3 random");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule